// File: doc/BRIEF.md
# Voice Interrupt Source Queue

This block gathers interrupt requests from the synthesizer voices and hands them to the host one source per read. Each voice can raise two kinds of request: a wavetable (sample position) event and a volume-ramp event. A one-cycle pulse on the matching event input sets a sticky pending bit for that voice and class. The host pops one source by writing the pop function code to the function-select register. That write picks a single pending source, clears it, and latches a status byte that tells the host which voice it was and which class it came from.

The block also keeps the global interrupt status byte. Two of its bits summarise the voice classes. The other bits belong to other sources (timers, DMA, legacy emulation), which set and clear them through pulse inputs. The interrupt line stays asserted while any bit of the global status byte is set. A chip-level clear pulse empties both request vectors and the global status byte.

Top module: `voice_irq_queue`

## Requirements
- R1: After the synchronous reset, both pending vectors are zero, the global status byte is 0x00, `irq_o` is low, the function-select register is 0x00 and the latched status byte is 0xE8.
- R2: An event pulse on `wave_evt[v]` or `ramp_evt[v]` sets the pending bit of voice v in that class from the next cycle. A wavetable event also sets global status bit 5, and a volume-ramp event also sets bit 6.
- R3: A write to the function-select register stores `fsel_wdata`. `rd_data` returns the latched status byte while the stored function is 0x8F, and 0xFF for any other stored function.
- R4: When a pop happens and any wavetable request is pending, a wavetable source is served even if volume-ramp requests are also pending.
- R5: Within the class being served, the lowest-numbered pending voice (0 to 30) is chosen.
- R6: A popped wavetable source latches status byte {3'b011, voice[4:0]} (voice | 0x60). A popped volume-ramp source latches {3'b100, voice[4:0]} (voice | 0x80).
- R7: A pop with both vectors empty latches 0xE8 and changes no pending bit.
- R8: A pop clears the chosen pending bit. For exactly the next cycle, it raises the matching bit of `wave_ctl_clr_o` or `ramp_ctl_clr_o`, which tells the owner of that voice's control register to clear bit 7. At most one of these bits is high in any cycle.
- R9: Global status bit 5 clears only when a pop empties the wavetable vector, and bit 6 clears only when a pop empties the volume-ramp vector. Each bit stays set while its vector is nonempty.
- R10: `irq_o` is high exactly when the global status byte is nonzero. It drops only when every bit is clear, including the bits owned by other sources.
- R11: A `chip_clr` pulse clears both pending vectors and the global status byte, and lowers `irq_o`. Event and set pulses in the same cycle are discarded.
- R12: An event pulse that arrives in the same cycle as a pop is kept, even when it is for the voice being popped.
- R13: A function-select write of any value other than 0x8F leaves the latched status byte and the pending vectors unchanged.
- R14: `ext_set` and `ext_clr` act on global status bits 0 to 4 and 7 only. Their bits 5 and 6 have no effect. If a bit is both set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_clr | input | 1 | Chip-level clear pulse for vectors and global status |
| wave_evt | input | NV | Per-voice wavetable event pulses |
| ramp_evt | input | NV | Per-voice volume-ramp event pulses |
| ext_set | input | 8 | Set pulses for the non-voice global status bits |
| ext_clr | input | 8 | Clear pulses for the non-voice global status bits |
| fsel_we | input | 1 | Function-select write strobe |
| fsel_wdata | input | 8 | Function-select write data |
| rd_data | output | 8 | Read value of the selected function |
| vstat_o | output | 8 | Latched voice interrupt status byte |
| gstat_o | output | 8 | Global interrupt status byte |
| irq_o | output | 1 | Interrupt line |
| wave_pend_o | output | NV | Pending wavetable requests |
| ramp_pend_o | output | NV | Pending volume-ramp requests |
| wave_ctl_clr_o | output | NV | One-cycle clear strobe for a voice's wave control bit 7 |
| ramp_ctl_clr_o | output | NV | One-cycle clear strobe for a voice's ramp control bit 7 |

## Verification
The bench sets up several cases where the choice of source matters:
- Wavetable and volume-ramp requests pending together. A design that served by voice number alone would return a 0x80-class code too early.
- Two voices pending in one class. Picking the highest index instead of the lowest would show up as the wrong byte.
- The pop that empties a class. A summary bit cleared on every pop, or never cleared, appears on `gstat_o`.
- An outside status bit still set when the voice classes empty. A design that drops the line too early is caught there.
- Pops that coincide with a new event for the same voice, to catch a design that loses that event.
- Pops on empty vectors, chip clears with events in the same cycle, and writes to other functions.

A random phase then runs against a cycle-by-cycle model of all these rules.

// File: rtl/vq_pkg.sv
package vq_pkg;

    localparam int unsigned VQ_VOICES     = 31;
    localparam int unsigned VQ_CODE_VW    = 5;
    localparam logic [7:0]  VQ_FN_POP     = 8'h8F;
    localparam logic [7:0]  VQ_EMPTY_CODE = 8'hE8;
    localparam logic [7:0]  VQ_RD_IDLE    = 8'hFF;
    localparam logic [2:0]  VQ_TAG_WAVE   = 3'b011;
    localparam logic [2:0]  VQ_TAG_RAMP   = 3'b100;
    localparam int unsigned VQ_WAVE_BIT   = 5;
    localparam int unsigned VQ_RAMP_BIT   = 6;
    localparam logic [7:0]  VQ_SUMMARY_MASK = 8'h60;
    localparam int unsigned VQ_CLASSES    = 2;
    localparam int unsigned VQ_CL_WAVE    = 0;
    localparam int unsigned VQ_CL_RAMP    = 1;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_WAVE = 2'd1,
        SRC_RAMP = 2'd2
    } vq_src_e;

    typedef struct packed {
        vq_src_e                 src;
        logic [VQ_CODE_VW-1:0]   voice;
    } vq_pick_t;

    function automatic logic [7:0] vq_encode(vq_pick_t p);
        case (p.src)
            SRC_WAVE: return {VQ_TAG_WAVE, p.voice};
            SRC_RAMP: return {VQ_TAG_RAMP, p.voice};
            default:  return VQ_EMPTY_CODE;
        endcase
    endfunction

endpackage

// File: rtl/vq_pick.sv
module vq_pick #(
    parameter int unsigned N  = 31,
    parameter int unsigned IW = 5
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  onehot
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        found  = |req;
        onehot = '0;
        for (int i = 0; i < N; i++) begin
            if (found && (idx == IW'(i))) onehot[i] = 1'b1;
        end
    end
endmodule

// File: rtl/vq_req_vec.sv
module vq_req_vec #(
    parameter int unsigned N  = 31,
    parameter int unsigned IW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [N-1:0]  evt,
    input  logic          pop,
    output logic [N-1:0]  pend,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  onehot,
    output logic          emptied
);
    logic [N-1:0] pend_q;
    logic [N-1:0] pend_n;
    logic [N-1:0] remain;

    vq_pick #(.N(N), .IW(IW)) u_pick (
        .req    (pend_q),
        .found  (found),
        .idx    (idx),
        .onehot (onehot)
    );

    always_comb begin
        remain  = pop ? (pend_q & ~onehot) : pend_q;
        emptied = pop && found && (remain == '0);
        pend_n  = clr ? '0 : (remain | evt);
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_n;
    end

    assign pend = pend_q;
endmodule

// File: rtl/vq_gstat.sv
module vq_gstat
    import vq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       wave_set,
    input  logic       wave_emptied,
    input  logic       ramp_set,
    input  logic       ramp_emptied,
    input  logic [7:0] ext_set,
    input  logic [7:0] ext_clr,
    output logic [7:0] gstat,
    output logic       irq
);
    logic [7:0] g_q;
    logic [7:0] g_n;

    always_comb begin
        g_n = ((g_q & ~ext_clr) | ext_set) & ~VQ_SUMMARY_MASK;
        g_n[VQ_WAVE_BIT] = (g_q[VQ_WAVE_BIT] & ~wave_emptied) | wave_set;
        g_n[VQ_RAMP_BIT] = (g_q[VQ_RAMP_BIT] & ~ramp_emptied) | ramp_set;
        if (clr) g_n = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            g_q <= '0;
            irq <= 1'b0;
        end else begin
            g_q <= g_n;
            irq <= |g_n;
        end
    end

    assign gstat = g_q;
endmodule

// File: rtl/voice_irq_queue.sv
module voice_irq_queue
    import vq_pkg::*;
#(
    parameter int unsigned NV = VQ_VOICES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          chip_clr,
    input  logic [NV-1:0] wave_evt,
    input  logic [NV-1:0] ramp_evt,
    input  logic [7:0]    ext_set,
    input  logic [7:0]    ext_clr,
    input  logic          fsel_we,
    input  logic [7:0]    fsel_wdata,
    output logic [7:0]    rd_data,
    output logic [7:0]    vstat_o,
    output logic [7:0]    gstat_o,
    output logic          irq_o,
    output logic [NV-1:0] wave_pend_o,
    output logic [NV-1:0] ramp_pend_o,
    output logic [NV-1:0] wave_ctl_clr_o,
    output logic [NV-1:0] ramp_ctl_clr_o
);
    localparam int unsigned IW = (NV > 1) ? $clog2(NV) : 1;

    logic [VQ_CLASSES-1:0][NV-1:0] evt_a;
    logic [VQ_CLASSES-1:0][NV-1:0] pend_a;
    logic [VQ_CLASSES-1:0][NV-1:0] oh_a;
    logic [VQ_CLASSES-1:0][NV-1:0] clr_q;
    logic [VQ_CLASSES-1:0][IW-1:0] idx_a;
    logic [VQ_CLASSES-1:0]         found_a;
    logic [VQ_CLASSES-1:0]         pop_a;
    logic [VQ_CLASSES-1:0]         empt_a;

    logic     pop_req;
    vq_pick_t pick;
    logic [7:0] fsel_q;
    logic [7:0] vstat_q;

    assign evt_a[VQ_CL_WAVE] = wave_evt;
    assign evt_a[VQ_CL_RAMP] = ramp_evt;

    assign pop_req = fsel_we && (fsel_wdata == VQ_FN_POP);

    // Wavetable class is always served first
    assign pop_a[VQ_CL_WAVE] = pop_req && found_a[VQ_CL_WAVE];
    assign pop_a[VQ_CL_RAMP] = pop_req && !found_a[VQ_CL_WAVE] && found_a[VQ_CL_RAMP];

    for (genvar c = 0; c < VQ_CLASSES; c++) begin : g_class
        vq_req_vec #(.N(NV), .IW(IW)) u_vec (
            .clk     (clk),
            .rst     (rst),
            .clr     (chip_clr),
            .evt     (evt_a[c]),
            .pop     (pop_a[c]),
            .pend    (pend_a[c]),
            .found   (found_a[c]),
            .idx     (idx_a[c]),
            .onehot  (oh_a[c]),
            .emptied (empt_a[c])
        );

        always_ff @(posedge clk) begin
            if (rst) clr_q[c] <= '0;
            else     clr_q[c] <= pop_a[c] ? oh_a[c] : '0;
        end
    end

    always_comb begin
        pick.src   = SRC_NONE;
        pick.voice = '0;
        if (found_a[VQ_CL_WAVE]) begin
            pick.src   = SRC_WAVE;
            pick.voice = VQ_CODE_VW'(idx_a[VQ_CL_WAVE]);
        end else if (found_a[VQ_CL_RAMP]) begin
            pick.src   = SRC_RAMP;
            pick.voice = VQ_CODE_VW'(idx_a[VQ_CL_RAMP]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsel_q  <= '0;
            vstat_q <= VQ_EMPTY_CODE;
        end else begin
            if (fsel_we) fsel_q  <= fsel_wdata;
            if (pop_req) vstat_q <= vq_encode(pick);
        end
    end

    vq_gstat u_gstat (
        .clk          (clk),
        .rst          (rst),
        .clr          (chip_clr),
        .wave_set     (|wave_evt),
        .wave_emptied (empt_a[VQ_CL_WAVE]),
        .ramp_set     (|ramp_evt),
        .ramp_emptied (empt_a[VQ_CL_RAMP]),
        .ext_set      (ext_set),
        .ext_clr      (ext_clr),
        .gstat        (gstat_o),
        .irq          (irq_o)
    );

    assign rd_data        = (fsel_q == VQ_FN_POP) ? vstat_q : VQ_RD_IDLE;
    assign vstat_o        = vstat_q;
    assign wave_pend_o    = pend_a[VQ_CL_WAVE];
    assign ramp_pend_o    = pend_a[VQ_CL_RAMP];
    assign wave_ctl_clr_o = clr_q[VQ_CL_WAVE];
    assign ramp_ctl_clr_o = clr_q[VQ_CL_RAMP];
endmodule

// File: rtl/voice_irq_queue_chk.sv
module voice_irq_queue_chk
    import vq_pkg::*;
#(
    parameter int unsigned NV = VQ_VOICES
) (
    input logic          clk,
    input logic          rst,
    input logic          fsel_we,
    input logic [7:0]    fsel_wdata,
    input logic [7:0]    vstat_o,
    input logic [7:0]    gstat_o,
    input logic          irq_o,
    input logic [NV-1:0] wave_pend_o,
    input logic [NV-1:0] ramp_pend_o,
    input logic [NV-1:0] wave_ctl_clr_o,
    input logic [NV-1:0] ramp_ctl_clr_o
);
    // R9
    wave_summary_chk: assert property (@(posedge clk) disable iff (rst)
        gstat_o[VQ_WAVE_BIT] == (wave_pend_o != '0));

    // R9
    ramp_summary_chk: assert property (@(posedge clk) disable iff (rst)
        gstat_o[VQ_RAMP_BIT] == (ramp_pend_o != '0));

    // R10
    irq_level_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o == (gstat_o != 8'h00));

    // R8
    single_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wave_ctl_clr_o, ramp_ctl_clr_o}));

    // R4
    wave_first_chk: assert property (@(posedge clk) disable iff (rst)
        (fsel_we && fsel_wdata == VQ_FN_POP && wave_pend_o != '0)
        |=> (ramp_ctl_clr_o == '0 && vstat_o[7:5] == VQ_TAG_WAVE));

    // R7
    empty_code_chk: assert property (@(posedge clk) disable iff (rst)
        (fsel_we && fsel_wdata == VQ_FN_POP && wave_pend_o == '0 && ramp_pend_o == '0)
        |=> (vstat_o == VQ_EMPTY_CODE));

    // R13
    no_pop_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !(fsel_we && fsel_wdata == VQ_FN_POP) |=> $stable(vstat_o));
endmodule

bind voice_irq_queue voice_irq_queue_chk #(.NV(NV)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .fsel_we        (fsel_we),
    .fsel_wdata     (fsel_wdata),
    .vstat_o        (vstat_o),
    .gstat_o        (gstat_o),
    .irq_o          (irq_o),
    .wave_pend_o    (wave_pend_o),
    .ramp_pend_o    (ramp_pend_o),
    .wave_ctl_clr_o (wave_ctl_clr_o),
    .ramp_ctl_clr_o (ramp_ctl_clr_o)
);

// File: tb/test_voice_irq_queue.sv
module test_voice_irq_queue;
    localparam int NV = 31;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          chip_clr = 1'b0;
    logic [NV-1:0] wave_evt = '0;
    logic [NV-1:0] ramp_evt = '0;
    logic [7:0]    ext_set = '0;
    logic [7:0]    ext_clr = '0;
    logic          fsel_we = 1'b0;
    logic [7:0]    fsel_wdata = '0;
    logic [7:0]    rd_data, vstat_o, gstat_o;
    logic          irq_o;
    logic [NV-1:0] wave_pend_o, ramp_pend_o, wave_ctl_clr_o, ramp_ctl_clr_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit running = 0;

    // behavioural reference state
    bit [NV-1:0] m_wp, m_rp, m_wclr, m_rclr;
    bit [7:0]    m_g, m_vs, m_fsel;

    always #5 clk = ~clk;

    voice_irq_queue #(.NV(NV)) i_voice_irq_queue (
        .clk(clk), .rst(rst), .chip_clr(chip_clr),
        .wave_evt(wave_evt), .ramp_evt(ramp_evt),
        .ext_set(ext_set), .ext_clr(ext_clr),
        .fsel_we(fsel_we), .fsel_wdata(fsel_wdata),
        .rd_data(rd_data), .vstat_o(vstat_o), .gstat_o(gstat_o), .irq_o(irq_o),
        .wave_pend_o(wave_pend_o), .ramp_pend_o(ramp_pend_o),
        .wave_ctl_clr_o(wave_ctl_clr_o), .ramp_ctl_clr_o(ramp_ctl_clr_o)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // reference model, one update per rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_wp = '0; m_rp = '0; m_wclr = '0; m_rclr = '0;
            m_g = 8'h00; m_vs = 8'hE8; m_fsel = 8'h00;
        end else begin
            bit [NV-1:0] wp, rp;
            bit [7:0] g;
            int v;
            wp = m_wp; rp = m_rp;
            m_wclr = '0; m_rclr = '0;
            if (fsel_we && fsel_wdata == 8'h8F) begin
                v = -1;
                if (wp != 0) begin
                    for (int i = 0; i < NV; i++) if (v < 0 && wp[i]) v = i;
                    wp[v] = 1'b0; m_wclr[v] = 1'b1;
                    m_vs = 8'h60 | 8'(v);
                end else if (rp != 0) begin
                    for (int i = 0; i < NV; i++) if (v < 0 && rp[i]) v = i;
                    rp[v] = 1'b0; m_rclr[v] = 1'b1;
                    m_vs = 8'h80 | 8'(v);
                end else begin
                    m_vs = 8'hE8;
                end
            end
            if (fsel_we) m_fsel = fsel_wdata;
            wp = wp | wave_evt;
            rp = rp | ramp_evt;
            g = ((m_g & ~ext_clr) | ext_set) & 8'h9F;
            if (wp != 0) g = g | 8'h20;
            if (rp != 0) g = g | 8'h40;
            if (chip_clr) begin
                wp = '0; rp = '0; g = 8'h00;
            end
            m_wp = wp; m_rp = rp; m_g = g;
        end
    end

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (running) begin
            chk("R2 wave_pend", wave_pend_o, m_wp);
            chk("R2 ramp_pend", ramp_pend_o, m_rp);
            chk("R9 gstat", gstat_o, m_g);
            chk("R10 irq", irq_o, (m_g != 0));
            chk("R6 vstat", vstat_o, m_vs);
            chk("R3 rd_data", rd_data, (m_fsel == 8'h8F) ? m_vs : 8'hFF);
            chk("R8 wave_ctl_clr", wave_ctl_clr_o, m_wclr);
            chk("R8 ramp_ctl_clr", ramp_ctl_clr_o, m_rclr);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic idle_in();
        chip_clr = 0; wave_evt = '0; ramp_evt = '0; ext_set = '0; ext_clr = '0;
        fsel_we = 0; fsel_wdata = '0;
    endtask

    task automatic tick();
        @(negedge clk);
        idle_in();
    endtask

    task automatic pop();
        fsel_we = 1; fsel_wdata = 8'h8F;
        tick();
    endtask

    initial begin
        idle_in();
        repeat (3) @(negedge clk);
        rst = 0;
        running = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 vstat", vstat_o, 8'hE8);
        chk("R1 gstat", gstat_o, 8'h00);
        chk("R1 irq", irq_o, 0);
        chk("R1 pend", {wave_pend_o, ramp_pend_o}, 0);

        // R2 wave event sets pend and summary
        wave_evt[2] = 1; tick();
        chk("R2 pend", wave_pend_o, 31'h4);
        chk("R2 gstat", gstat_o, 8'h20);

        // R13 other function write does nothing to queue
        fsel_we = 1; fsel_wdata = 8'h03; tick();
        chk("R13 vstat", vstat_o, 8'hE8);
        chk("R13 pend", wave_pend_o, 31'h4);
        chk("R3 rd idle", rd_data, 8'hFF);

        wave_evt[7] = 1; ramp_evt[0] = 1; tick();
        // R4 R5 R6 lowest wave voice before ramp
        pop();
        chk("R4 vstat", vstat_o, 8'h62);
        chk("R3 rd", rd_data, 8'h62);
        chk("R8 clr", wave_ctl_clr_o, 31'h4);
        chk("R9 gstat", gstat_o, 8'h60);
        pop();
        chk("R5 vstat", vstat_o, 8'h67);
        chk("R9 wave empty", gstat_o, 8'h40);
        pop();
        chk("R6 vstat", vstat_o, 8'h80);
        chk("R10 irq low", irq_o, 0);
        pop();
        chk("R7 vstat", vstat_o, 8'hE8);

        // R14 summary bits not writable from outside
        ext_set = 8'h24; ramp_evt[30] = 1; tick();
        chk("R14 gstat", gstat_o, 8'h44);
        pop();
        chk("R6 vstat", vstat_o, 8'h9E);
        chk("R10 gstat", gstat_o, 8'h04);
        chk("R10 irq held", irq_o, 1);
        ext_clr = 8'h64; tick();
        chk("R14 clr", gstat_o, 8'h00);
        chk("R10 irq low", irq_o, 0);

        // R12 same-cycle event retained
        wave_evt[3] = 1; tick();
        wave_evt[3] = 1; wave_evt[1] = 1; fsel_we = 1; fsel_wdata = 8'h8F; tick();
        chk("R12 vstat", vstat_o, 8'h63);
        chk("R12 pend", wave_pend_o, 31'h0A);
        chk("R12 gstat", gstat_o, 8'h20);

        // R11 chip clear wins over same-cycle events
        ramp_evt[5] = 1; ext_set = 8'h01; tick();
        chip_clr = 1; ramp_evt[9] = 1; wave_evt[0] = 1; tick();
        chk("R11 pend", {wave_pend_o, ramp_pend_o}, 0);
        chk("R11 gstat", gstat_o, 8'h00);
        chk("R11 irq", irq_o, 0);

        // random phase against the model
        for (int n = 0; n < 2000; n++) begin
            wave_evt = NV'($urandom & $urandom & $urandom);
            ramp_evt = NV'($urandom & $urandom & $urandom);
            ext_set  = 8'($urandom & $urandom & $urandom);
            ext_clr  = 8'($urandom & $urandom);
            chip_clr = ($urandom_range(0, 63) == 0);
            fsel_we  = ($urandom_range(0, 2) != 0);
            fsel_wdata = ($urandom_range(0, 3) != 0) ? 8'h8F : 8'($urandom);
            tick();
        end

        running = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule